// File: doc/BRIEF.md
# Programmable Johnson-Ring Frequency Divider

This block divides its clock by any integer from 2 to 10 using a five-stage twisted-ring (Johnson) shift register. A 4-bit ratio input chooses the feedback network into the first stage. For an even ratio, one inverted stage output is fed back. For an odd ratio, two adjacent stage outputs are combined through a NAND, which removes one state from each revolution of the ring.

The register has an asynchronous clear and an asynchronous parallel load. The load copies five load-value inputs into the stages. Recovery logic watches the stages that the selected ratio uses. If their pattern is not a valid Johnson pattern, it clears the ring on the next clock edge. The divided clock is taken from the highest stage in use. The stage outputs are also visible, so a user can decode phases from them.

Top module: `jdiv_top`

## Requirements
- R1: While `rst_ni` is low, all five stages read 0 at once, without waiting for a clock edge.
- R2: While `preset_i` is high and `rst_ni` is high, the stages read `jam_i` at once and keep reloading it on each clock edge. If `rst_ni` is low, the clear wins over the load.
- R3: The state changes only on a rising edge of `clk_i`. On each such edge in normal counting, stage i+1 (bit i) takes the old value of stage i (bit i-1). Bit 0 is stage 1.
- R4: For an even ratio 2m (m = 1..5), bit 0 takes the inverse of bit m-1 on each edge. `div_o` then has a period of exactly 2m clocks, with m high and m low.
- R5: For an odd ratio 2k-1 (k = 2..5), bit 0 takes NAND(bit k-1, bit k-2) on each edge. `div_o` then has a period of exactly 2k-1 clocks.
- R6: The ratio values 0, 1 and 11 to 15 behave exactly like ratio 10.
- R7: Let n = (ratio+1)/2 be the number of active stages, with the ratio taken after the substitution of R6. If bits 0..n-1 show more than one change between neighbouring bits, all five bits become 0 on the next edge. Bits at index n or above never trigger this clearing.
- R8: `div_o` always equals bit n-1 of the stages, where n is the active-stage count from R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock; the state moves on the rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| preset_i | input | 1 | Asynchronous parallel load of `jam_i`, active high |
| jam_i | input | 5 | Load values; bit 0 goes to stage 1 |
| ratio_i | input | 4 | Division ratio, legal values 2 to 10 |
| stage_o | output | 5 | Ring stage outputs; bit 0 is stage 1 |
| div_o | output | 1 | Divided clock, taken from the highest active stage |

## Verification
The bench measures the period of `div_o` for every ratio from 2 to 10 and for out-of-range ratio codes. It checks the duty cycle for even ratios. A wrong tap or a wrong NAND pairing would show up as a period one or two clocks off, or as a ring that never settles into its cycle.

Invalid patterns are loaded through the preset. A recovery check that is missing or ignores the ratio would leave the ring cycling with the bad pattern, or would clear on noise in stages the ratio does not use. Reset and preset are asserted together, and a design with the wrong priority would show the load values instead of zeros.

A cycle-accurate model follows every clock edge, so a stage that changes between edges or shifts the wrong way is flagged on the same cycle.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  localparam int unsigned JD_STAGES = 5;
  localparam int unsigned JD_RW     = $clog2(2 * JD_STAGES + 1);
  localparam int unsigned JD_CW     = $clog2(JD_STAGES + 1);

  typedef logic [JD_STAGES-1:0] jd_state_t;

  typedef struct packed {
    logic             odd;
    logic [JD_CW-1:0] act;  // number of stages in the ring
  } jd_cfg_t;
endpackage

// File: rtl/jdiv_ratio_dec.sv
module jdiv_ratio_dec
  import jdiv_pkg::*;
(
  input  logic [JD_RW-1:0] ratio_i,
  output jd_cfg_t          cfg_o,
  output jd_state_t        mask_o
);
  localparam logic [JD_RW-1:0] MAX_R = JD_RW'(2 * JD_STAGES);
  localparam logic [JD_RW-1:0] MIN_R = JD_RW'(2);

  logic             legal;
  logic [JD_RW-1:0] eff;
  logic [JD_RW:0]   half_up;

  assign legal   = (ratio_i >= MIN_R) && (ratio_i <= MAX_R);
  assign eff     = legal ? ratio_i : MAX_R;
  assign half_up = ({1'b0, eff} + (JD_RW+1)'(1)) >> 1;

  assign cfg_o.odd = eff[0];
  assign cfg_o.act = JD_CW'(half_up);

  for (genvar i = 0; i < JD_STAGES; i++) begin : g_mask
    assign mask_o[i] = (JD_CW'(i) < cfg_o.act);
  end
endmodule

// File: rtl/jdiv_fb.sv
module jdiv_fb
  import jdiv_pkg::*;
(
  input  jd_state_t state_i,
  input  jd_cfg_t   cfg_i,
  input  jd_state_t mask_i,
  output logic      data_o,
  output logic      lock_o
);
  jd_state_t              lower;
  logic                   hi;
  logic                   lo;
  logic [JD_STAGES-2:0]   step_v;

  // lower[i] holds the stage just below stage i; constant 1 under stage 1
  assign lower = {state_i[JD_STAGES-2:0], 1'b1};

  always_comb begin
    hi = 1'b0;
    lo = 1'b1;
    for (int i = 0; i < JD_STAGES; i++) begin
      if (cfg_i.act == JD_CW'(i + 1)) begin
        hi = state_i[i];
        lo = lower[i];
      end
    end
  end

  assign data_o = cfg_i.odd ? ~(hi & lo) : ~hi;

  for (genvar i = 1; i < JD_STAGES; i++) begin : g_step
    assign step_v[i-1] = (state_i[i] ^ state_i[i-1]) & mask_i[i];
  end

  assign lock_o = ($countones(step_v) > 1);
endmodule

// File: rtl/jdiv_top.sv
module jdiv_top
  import jdiv_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 preset_i,
  input  logic [JD_STAGES-1:0] jam_i,
  input  logic [JD_RW-1:0]     ratio_i,
  output logic [JD_STAGES-1:0] stage_o,
  output logic                 div_o
);
  jd_cfg_t   cfg;
  jd_state_t mask;
  jd_state_t q;
  jd_state_t q_nxt;
  logic      fb;
  logic      lock;

  jdiv_ratio_dec u_dec (
    .ratio_i (ratio_i),
    .cfg_o   (cfg),
    .mask_o  (mask)
  );

  jdiv_fb u_fb (
    .state_i (q),
    .cfg_i   (cfg),
    .mask_i  (mask),
    .data_o  (fb),
    .lock_o  (lock)
  );

  assign q_nxt = lock ? '0 : {q[JD_STAGES-2:0], fb};

  // clear beats load; both act without a clock edge
  always_ff @(posedge clk_i or negedge rst_ni or posedge preset_i) begin
    if (!rst_ni)       q <= '0;
    else if (preset_i) q <= jam_i;
    else               q <= q_nxt;
  end

  always_comb begin
    div_o = 1'b0;
    for (int i = 0; i < JD_STAGES; i++) begin
      if (cfg.act == JD_CW'(i + 1)) div_o = q[i];
    end
  end

  assign stage_o = q;
endmodule

// File: rtl/jdiv_chk.sv
module jdiv_chk
  import jdiv_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 preset_i,
  input logic [JD_STAGES-1:0] jam_i,
  input logic [JD_RW-1:0]     ratio_i,
  input logic [JD_STAGES-1:0] stage_o,
  input logic                 div_o,
  input logic                 lock_i
);
  int   eff_r;
  int   act_n;
  int   steps;
  logic lock_exp;
  logic data_exp;
  logic div_exp;

  always_comb begin
    eff_r = (int'(ratio_i) >= 2 && int'(ratio_i) <= 2 * JD_STAGES) ? int'(ratio_i) : 2 * JD_STAGES;
    act_n = (eff_r + 1) / 2;
    steps = 0;
    for (int i = 1; i < JD_STAGES; i++)
      if (i < act_n && stage_o[i] != stage_o[i-1]) steps++;
    lock_exp = (steps > 1);
    data_exp = 1'b0;
    div_exp  = 1'b0;
    for (int i = 0; i < JD_STAGES; i++) begin
      if (i == act_n - 1) begin
        div_exp = stage_o[i];
        if (eff_r % 2 == 0) data_exp = ~stage_o[i];
        else                data_exp = ~(stage_o[i] & ((i > 0) ? stage_o[(i > 0) ? i - 1 : 0] : 1'b1));
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> stage_o == '0);

  // R2
  preset_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_i && $past(preset_i) && $past(rst_ni)) |-> stage_o == jam_i);

  // R3
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && !lock_exp) |=> (preset_i || stage_o[JD_STAGES-1:1] == $past(stage_o[JD_STAGES-2:0])));

  // R4 R5
  feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && !lock_exp) |=> (preset_i || stage_o[0] == $past(data_exp)));

  // R7
  antilock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && lock_exp) |=> (preset_i || stage_o == '0));

  // R7
  lock_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_i == lock_exp);

  // R8
  div_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) div_o == div_exp);
endmodule

bind jdiv_top jdiv_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .preset_i (preset_i),
  .jam_i    (jam_i),
  .ratio_i  (ratio_i),
  .stage_o  (stage_o),
  .div_o    (div_o),
  .lock_i   (lock)
);

// File: tb/tb_jdiv_top.sv
`timescale 1ns/1ps
module tb_jdiv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       preset = 1'b0;
  logic [4:0] jam = 5'd0;
  logic [3:0] ratio = 4'd10;
  logic [4:0] stage;
  logic       div;

  int total = 0;
  int bad = 0;
  int mdl[5];
  bit run_cmp = 1'b0;

  jdiv_top dut (
    .clk_i(clk), .rst_ni(rst_n), .preset_i(preset), .jam_i(jam),
    .ratio_i(ratio), .stage_o(stage), .div_o(div)
  );

  always #10 clk = ~clk;

  function automatic int eff_ratio(int r);
    return (r >= 2 && r <= 10) ? r : 10;
  endfunction

  function automatic int mdl_val();
    int v = 0;
    for (int i = 0; i < 5; i++) v += mdl[i] << i;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    int n, k, cnt, d;
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) mdl[i] = 0;
    end else if (preset) begin
      for (int i = 0; i < 5; i++) mdl[i] = jam[i];
    end else begin
      n = eff_ratio(int'(ratio));
      k = (n + 1) / 2;
      cnt = 0;
      for (int i = 1; i < k; i++) if (mdl[i] != mdl[i-1]) cnt++;
      if (cnt > 1) begin
        for (int i = 0; i < 5; i++) mdl[i] = 0;
      end else begin
        if (n % 2 == 0) d = 1 - mdl[k-1];
        else            d = (mdl[k-1] == 1 && mdl[k-2] == 1) ? 0 : 1;
        for (int i = 4; i > 0; i--) mdl[i] = mdl[i-1];
        mdl[0] = d;
      end
    end
  endtask

  always @(posedge clk) begin
    int k;
    model_step();
    #5;
    if (run_cmp) begin
      k = (eff_ratio(int'(ratio)) + 1) / 2;
      chk("R3 stage vs model", int'(stage), mdl_val());
      chk("R8 div vs model", int'(div), mdl[k-1]);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 5; i++) mdl[i] = 0;
    chk("R1 async clear", int'(stage), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_preset(logic [4:0] v);
    @(negedge clk);
    jam = v;
    preset = 1'b1;
    #1;
    for (int i = 0; i < 5; i++) mdl[i] = v[i];
    chk("R2 async load", int'(stage), int'(v));
    @(negedge clk);
    @(negedge clk);
    preset = 1'b0;
  endtask

  task automatic period(int n, string req);
    int t0 = -1;
    int c = 0;
    logic prev = div;
    for (int j = 0; j < 60; j++) begin
      @(posedge clk);
      #6;
      c++;
      if (div && !prev) begin
        if (t0 < 0) t0 = c;
        else begin
          chk(req, c - t0, n);
          break;
        end
      end
      prev = div;
    end
  endtask

  task automatic duty(int n);
    int hi = 0;
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      #6;
      if (div) hi++;
    end
    chk("R4 duty", hi, n / 2);
  endtask

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] snap;
    #5;
    do_reset();
    chk("R1 reset stage", int'(stage), 0);
    chk("R1 reset div", int'(div), 0);
    run_cmp = 1'b1;

    // R4 R5 every legal ratio
    for (int r = 2; r <= 10; r++) begin
      @(negedge clk);
      ratio = 4'(r);
      do_reset();
      period(r, (r % 2 == 0) ? "R4 period" : "R5 period");
      if (r % 2 == 0) duty(r);
    end

    // R6 out-of-range codes
    begin
      int codes[3] = '{0, 1, 15};
      foreach (codes[j]) begin
        @(negedge clk);
        ratio = 4'(codes[j]);
        do_reset();
        period(10, "R6 default ratio");
      end
    end

    // R3 nothing moves between edges
    @(posedge clk);
    #6;
    snap = stage;
    @(negedge clk);
    #3;
    chk("R3 stable mid-cycle", int'(stage), int'(snap));

    // R7 anti-lock on full ring
    @(negedge clk);
    ratio = 4'd10;
    do_preset(5'b00101);
    @(posedge clk);
    #6;
    chk("R7 clear ratio10", int'(stage), 0);

    // R7 anti-lock on three-stage ring
    @(negedge clk);
    ratio = 4'd6;
    do_preset(5'b01010);
    @(posedge clk);
    #6;
    chk("R7 clear ratio6", int'(stage), 0);

    // R7 inactive stages ignored
    @(negedge clk);
    ratio = 4'd4;
    do_preset(5'b10100);
    @(posedge clk);
    #6;
    chk("R7 inactive ignored", int'(stage), 5'b01001);

    // R2 clear wins over load
    @(negedge clk);
    jam = 5'b11111;
    preset = 1'b1;
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 5; i++) mdl[i] = 0;
    chk("R2 clear priority", int'(stage), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #6;
    chk("R2 load after clear", int'(stage), 5'b11111);
    @(negedge clk);
    preset = 1'b0;
    ratio = 4'd7;
    period(7, "R5 period after load");

    repeat (3) @(posedge clk);
    #8;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule